// File: doc/BRIEF.md
# Flash Block Lock Manager

This block holds a write-protection state for each erase block of a flash array and changes those states on command. Each block is in exactly one of three states: unlocked, locked, or lock-tight. Lock-tight is sticky: no command can leave it, only a reset. Software picks a range of blocks with two range registers. It then writes a command code. The block walks the range one block per clock, updates a status register with the last state it wrote, and raises a one-cycle completion pulse. While a walk runs, the block reports busy and ignores any further command writes.

The per-block states live in a small dual-port memory that maps onto FPGA block RAM. Because block RAM cannot be cleared by reset, a reset starts a sweep that writes the locked state into every block, one per clock, with busy held high. Software can read the state of any block through a query port. The result is registered and arrives one clock after the index is presented.

Top module: `blk_lock_mgr`

## Requirements
- R1: Block states are one-hot: 3'b001 lock-tight, 3'b010 locked, 3'b100 unlocked. `query_state` shows the state of block `query_idx`, captured at the clock edge after the index is presented while the block is idle. `wp_status` always holds one of these codes in bits 2:0 and zeros above.
- R2: After reset, `busy` stays high for exactly NUM_BLOCKS clock edges after reset is released. After that, every block reads locked. `wp_status` reads 16'h0002 and `done`, `cmd_err`, `range_start` and `range_end` read zero.
- R3: A write to register address 0 loads both `range_start` and `range_end` with `reg_wdata` masked by NUM_BLOCKS-1.
- R4: A write to register address 1 loads only `range_end` with the masked value. `range_start` is left unchanged.
- R5: Command 16'h0023 (written to address 2) sets every block from start to end inclusive to unlocked. `wp_status` becomes 16'h0004.
- R6: Command 16'h002A sets every block from start to end inclusive to locked. `wp_status` becomes 16'h0002.
- R7: Unlock, unlock-all and lock walks stop at the first lock-tight block they meet. Blocks before it are changed; it and the blocks after it are not.
- R8: Command 16'h002C leaves unlocked blocks in the range as they are and carries on past them. It turns every other block in the range into lock-tight, and `wp_status` becomes 16'h0001 if at least one block was converted.
- R9: Command 16'h0027 walks blocks 0 to NUM_BLOCKS-1 with the unlock rule, ignoring the range registers.
- R10: A walk that handles K blocks (a stopping block counts) holds `busy` high and raises `done` for one cycle, K+1 clock edges after the edge that accepts the command. `done` is never high together with `busy`.
- R11: A command write while `busy` is high has no effect on any block or on the walk in progress.
- R12: An unknown command code, or a range whose start exceeds its end, raises `done` on the accepting edge and changes no block. An unknown code sets `cmd_err`; every accepted command first clears `cmd_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 range start, 1 range end, 2 command |
| reg_wdata | input | 16 | Register write data |
| query_idx | input | AW | Index of the block to read back |
| range_start | output | AW | First block of the range |
| range_end | output | AW | Last block of the range |
| wp_status | output | 16 | Last state written by a walk |
| query_state | output | 3 | State of the queried block |
| busy | output | 1 | Reset sweep or walk in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| cmd_err | output | 1 | Command error flag |

## Verification
The assertions assume that reset is held for at least one clock edge before checking begins. They also assume that query results are only trusted once `busy` has been low for a full cycle, because the query port yields to the walker's writes. The stimulus issues each command and then waits for `done` before the next one. The one exception is a command written on purpose while a walk is still running. Range registers are written only while the block is idle, so the range a walk latched and the range the registers show never disagree during a check.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

  typedef enum logic [2:0] {
    LS_TIGHT    = 3'b001,
    LS_LOCKED   = 3'b010,
    LS_UNLOCKED = 3'b100
  } lock_state_e;

  typedef enum logic [1:0] {
    OP_UNLOCK = 2'd0,
    OP_LOCK   = 2'd1,
    OP_TIGHT  = 2'd2
  } walk_op_e;

  localparam logic [15:0] CMD_UNLOCK_RANGE = 16'h0023;
  localparam logic [15:0] CMD_UNLOCK_ALL   = 16'h0027;
  localparam logic [15:0] CMD_LOCK_RANGE   = 16'h002A;
  localparam logic [15:0] CMD_TIGHT_RANGE  = 16'h002C;

  localparam logic [1:0] RSEL_START = 2'd0;
  localparam logic [1:0] RSEL_END   = 2'd1;
  localparam logic [1:0] RSEL_CMD   = 2'd2;

  localparam logic [15:0] WP_RESET = 16'h0002;

endpackage

// File: rtl/lock_state_ram.sv
module lock_state_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int DW    = 3
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_waddr,
  input  logic [DW-1:0] a_wdata,
  input  logic [AW-1:0] a_raddr,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_raddr,
  output logic [DW-1:0] b_rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Port A: write has priority, otherwise a registered read for the query path.
  always_ff @(posedge clk) begin
    if (a_we) begin
      mem[a_waddr] <= a_wdata;
    end else begin
      a_rdata <= mem[a_raddr];
    end
  end

  // Port B: registered read used by the walker.
  always_ff @(posedge clk) begin
    b_rdata <= mem[b_raddr];
  end

endmodule

// File: rtl/lock_range_regs.sv
module lock_range_regs #(
  parameter int NUM_BLOCKS = 64,
  parameter int AW         = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] start_idx,
  output logic [AW-1:0] end_idx
);
  import blk_lock_pkg::*;

  localparam logic [AW-1:0] IDX_MASK = AW'(NUM_BLOCKS - 1);

  logic [AW-1:0] masked;
  assign masked = wdata & IDX_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_idx <= '0;
      end_idx   <= '0;
    end else if (we) begin
      if (sel == RSEL_START) begin
        start_idx <= masked;
        end_idx   <= masked;
      end else if (sel == RSEL_END) begin
        end_idx <= masked;
      end
    end
  end

endmodule

// File: rtl/lock_walker.sv
module lock_walker #(
  parameter int NUM_BLOCKS = 64,
  parameter int AW         = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_we,
  input  logic [15:0]   cmd_code,
  input  logic [AW-1:0] start_idx,
  input  logic [AW-1:0] end_idx,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [2:0]    ram_wdata,
  output logic [AW-1:0] ram_raddr,
  input  logic [2:0]    ram_rdata,
  output logic          busy,
  output logic          done,
  output logic          cmd_err,
  output logic [15:0]   wp_status
);
  import blk_lock_pkg::*;

  localparam int IW = AW + 1;
  localparam logic [IW-1:0] LAST_BLOCK = IW'(NUM_BLOCKS - 1);
  localparam logic [IW-1:0] BLOCK_LIM  = IW'(NUM_BLOCKS);
  localparam logic [AW-1:0] INIT_LAST  = AW'(NUM_BLOCKS - 1);

  typedef enum logic [1:0] {W_INIT, W_IDLE, W_RUN} wstate_e;

  wstate_e      wst;
  walk_op_e     op_q;
  logic [AW-1:0] init_idx;
  logic [IW-1:0] issue_idx;
  logic [IW-1:0] last_idx;
  logic          pend_vld;
  logic [IW-1:0] pend_idx;

  // Command decode
  logic          dec_known;
  walk_op_e      dec_op;
  logic [IW-1:0] dec_first;
  logic [IW-1:0] dec_last;

  always_comb begin
    dec_known = 1'b1;
    dec_op    = OP_UNLOCK;
    dec_first = {1'b0, start_idx};
    dec_last  = {1'b0, end_idx};
    case (cmd_code)
      CMD_UNLOCK_RANGE: dec_op = OP_UNLOCK;
      CMD_LOCK_RANGE:   dec_op = OP_LOCK;
      CMD_TIGHT_RANGE:  dec_op = OP_TIGHT;
      CMD_UNLOCK_ALL: begin
        dec_op    = OP_UNLOCK;
        dec_first = '0;
        dec_last  = LAST_BLOCK;
      end
      default: dec_known = 1'b0;
    endcase
  end

  logic cmd_fire;
  assign cmd_fire = cmd_we && (wst == W_IDLE);

  // Stage that acts on the block whose state was read last cycle
  lock_state_e cur_state;
  lock_state_e new_state;
  logic        out_of_range;
  logic        hit_tight;
  logic        skip_blk;
  logic        blk_write;
  logic        finish;

  always_comb begin
    cur_state    = lock_state_e'(ram_rdata);
    out_of_range = pend_idx >= BLOCK_LIM;
    hit_tight    = (op_q != OP_TIGHT) && (cur_state == LS_TIGHT);
    skip_blk     = (op_q == OP_TIGHT) && (cur_state == LS_UNLOCKED);
    case (op_q)
      OP_LOCK:  new_state = LS_LOCKED;
      OP_TIGHT: new_state = LS_TIGHT;
      default:  new_state = LS_UNLOCKED;
    endcase
    blk_write = (wst == W_RUN) && pend_vld && !out_of_range && !hit_tight && !skip_blk;
    finish    = (wst == W_RUN) && pend_vld &&
                (out_of_range || hit_tight || (pend_idx == last_idx));
  end

  logic issue;
  assign issue = (wst == W_RUN) && (issue_idx <= last_idx) && !finish;

  // Memory ports
  always_comb begin
    ram_raddr = issue_idx[AW-1:0];
    if (wst == W_INIT) begin
      ram_we    = 1'b1;
      ram_waddr = init_idx;
      ram_wdata = LS_LOCKED;
    end else begin
      ram_we    = blk_write;
      ram_waddr = pend_idx[AW-1:0];
      ram_wdata = new_state;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wst       <= W_INIT;
      op_q      <= OP_LOCK;
      init_idx  <= '0;
      issue_idx <= '0;
      last_idx  <= '0;
      pend_vld  <= 1'b0;
      pend_idx  <= '0;
      busy      <= 1'b1;
      done      <= 1'b0;
      cmd_err   <= 1'b0;
      wp_status <= WP_RESET;
    end else begin
      done <= 1'b0;
      case (wst)
        W_INIT: begin
          init_idx <= init_idx + 1'b1;
          if (init_idx == INIT_LAST) begin
            wst  <= W_IDLE;
            busy <= 1'b0;
          end
        end
        W_IDLE: begin
          if (cmd_fire) begin
            cmd_err <= !dec_known;
            if (!dec_known || (dec_first > dec_last)) begin
              done <= 1'b1;
            end else begin
              wst       <= W_RUN;
              busy      <= 1'b1;
              op_q      <= dec_op;
              issue_idx <= dec_first;
              last_idx  <= dec_last;
              pend_vld  <= 1'b0;
            end
          end
        end
        W_RUN: begin
          if (issue) begin
            pend_vld  <= 1'b1;
            pend_idx  <= issue_idx;
            issue_idx <= issue_idx + 1'b1;
          end else begin
            pend_vld <= 1'b0;
          end
          if (blk_write) begin
            wp_status <= {13'b0, new_state};
          end
          if (pend_vld && out_of_range) begin
            cmd_err <= 1'b1;
          end
          if (finish) begin
            wst      <= W_IDLE;
            busy     <= 1'b0;
            done     <= 1'b1;
            pend_vld <= 1'b0;
          end
        end
        default: wst <= W_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/blk_lock_mgr.sv
module blk_lock_mgr #(
  parameter int NUM_BLOCKS = 64,
  localparam int AW = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  input  logic [AW-1:0] query_idx,
  output logic [AW-1:0] range_start,
  output logic [AW-1:0] range_end,
  output logic [15:0]   wp_status,
  output logic [2:0]    query_state,
  output logic          busy,
  output logic          done,
  output logic          cmd_err
);
  import blk_lock_pkg::*;

  logic          cmd_we;
  logic          ram_we;
  logic [AW-1:0] ram_waddr;
  logic [2:0]    ram_wdata;
  logic [AW-1:0] ram_raddr;
  logic [2:0]    ram_rdata;

  assign cmd_we = reg_we && (reg_addr == RSEL_CMD);

  lock_range_regs #(.NUM_BLOCKS(NUM_BLOCKS), .AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (reg_we),
    .sel       (reg_addr),
    .wdata     (reg_wdata[AW-1:0]),
    .start_idx (range_start),
    .end_idx   (range_end)
  );

  lock_walker #(.NUM_BLOCKS(NUM_BLOCKS), .AW(AW)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .cmd_we    (cmd_we),
    .cmd_code  (reg_wdata),
    .start_idx (range_start),
    .end_idx   (range_end),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata),
    .ram_raddr (ram_raddr),
    .ram_rdata (ram_rdata),
    .busy      (busy),
    .done      (done),
    .cmd_err   (cmd_err),
    .wp_status (wp_status)
  );

  lock_state_ram #(.DEPTH(NUM_BLOCKS), .AW(AW), .DW(3)) u_ram (
    .clk     (clk),
    .a_we    (ram_we),
    .a_waddr (ram_waddr),
    .a_wdata (ram_wdata),
    .a_raddr (query_idx),
    .a_rdata (query_state),
    .b_raddr (ram_raddr),
    .b_rdata (ram_rdata)
  );

endmodule

// File: rtl/blk_lock_mgr_chk.sv
module blk_lock_mgr_chk #(
  parameter int NUM_BLOCKS = 64,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_we,
  input logic [1:0]    reg_addr,
  input logic [AW-1:0] wdata_lo,
  input logic [AW-1:0] range_start,
  input logic [AW-1:0] range_end,
  input logic [15:0]   wp_status,
  input logic [2:0]    query_state,
  input logic          busy,
  input logic          done,
  input logic          cmd_err
);

  localparam logic [AW-1:0] IDX_MASK = AW'(NUM_BLOCKS - 1);

  p_status_code_r1: assert property (@(posedge clk) disable iff (rst)
    ($countones(wp_status[2:0]) == 1) && (wp_status[15:3] == 13'b0));

  p_query_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> ($countones(query_state) == 1));

  p_reset_status_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wp_status == 16'h0002 && busy && !done && !cmd_err));

  p_start_loads_both_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'd0) |=>
      (range_start == ($past(wdata_lo) & IDX_MASK)) && (range_end == range_start));

  p_end_only_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'd1) |=>
      (range_end == ($past(wdata_lo) & IDX_MASK)) && $stable(range_start));

  p_done_not_busy_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_err_with_done_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_err) |-> done);

endmodule

bind blk_lock_mgr blk_lock_mgr_chk #(.NUM_BLOCKS(NUM_BLOCKS), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .wdata_lo    (reg_wdata[AW-1:0]),
  .range_start (range_start),
  .range_end   (range_end),
  .wp_status   (wp_status),
  .query_state (query_state),
  .busy        (busy),
  .done        (done),
  .cmd_err     (cmd_err)
);

// File: tb/blk_lock_mgr_test.sv
`timescale 1ns/1ps
module blk_lock_mgr_test;

  localparam int N  = 64;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [15:0]   reg_wdata = '0;
  logic [AW-1:0] query_idx = '0;
  logic [AW-1:0] range_start;
  logic [AW-1:0] range_end;
  logic [15:0]   wp_status;
  logic [2:0]    query_state;
  logic          busy;
  logic          done;
  logic          cmd_err;

  blk_lock_mgr #(.NUM_BLOCKS(N)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .query_idx(query_idx),
    .range_start(range_start), .range_end(range_end),
    .wp_status(wp_status), .query_state(query_state),
    .busy(busy), .done(done), .cmd_err(cmd_err)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int exp_st [N];
  int exp_wp = 2;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  // Reference behaviour of a command, derived from the requirements.
  task automatic model_cmd(input int code, input int s, input int e, output int nproc);
    int lo = s;
    int hi = e;
    nproc = 0;
    if (code == 'h27) begin lo = 0; hi = N - 1; end
    if (code != 'h23 && code != 'h27 && code != 'h2A && code != 'h2C) return;
    for (int b = lo; b <= hi; b++) begin
      nproc++;
      if (code == 'h2C) begin
        if (exp_st[b] == 4) continue;
        exp_st[b] = 1;
        exp_wp = 1;
      end else begin
        if (exp_st[b] == 1) break;
        exp_st[b] = (code == 'h2A) ? 2 : 4;
        exp_wp = exp_st[b];
      end
    end
  endtask

  task automatic check_blocks(input string req);
    for (int i = 0; i < N; i++) begin
      query_idx = AW'(i);
      @(posedge clk);
      @(negedge clk);
      chk(query_state == 3'(exp_st[i]), req, $sformatf("block %0d state", i),
          int'(query_state), exp_st[i]);
    end
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 1000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_cmd(input int code, input int s, input int e, input string req);
    int nproc;
    int n;
    int exp_n;
    reg_wr(2'd0, 16'(s));
    reg_wr(2'd1, 16'(e));
    model_cmd(code, s, e, nproc);
    exp_n = (nproc == 0) ? 0 : nproc + 1;
    reg_wr(2'd2, 16'(code));
    wait_done(n);
    chk(n == exp_n, req, "R10 edges from accept to done", n, exp_n);
    chk(done && !busy, req, "R10 done high with busy low", int'({done, busy}), 2);
    chk(wp_status == 16'(exp_wp), req, "status register", int'(wp_status), exp_wp);
    chk(cmd_err == 1'b0, req, "R12 error flag clear", int'(cmd_err), 0);
    @(posedge clk);
    @(negedge clk);
    chk(!done, req, "R10 done is one cycle", int'(done), 0);
    check_blocks(req);
  endtask

  task automatic t_reset();
    int n = 0;
    chk(busy == 1'b1, "R2", "busy right after reset", int'(busy), 1);
    chk(wp_status == 16'h0002, "R2", "status after reset", int'(wp_status), 2);
    chk(!done && !cmd_err, "R2", "done/err after reset", int'({done, cmd_err}), 0);
    chk(range_start == 0 && range_end == 0, "R2", "range regs after reset",
        int'({range_start, range_end}), 0);
    while (busy && n < 1000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    chk(n == N, "R2", "init sweep length", n, N);
    for (int i = 0; i < N; i++) exp_st[i] = 2;
    check_blocks("R2 R1");
  endtask

  task automatic t_range_regs();
    reg_wr(2'd0, 16'h0005);
    chk(range_start == 5 && range_end == 5, "R3", "start write loads both",
        int'({range_start, range_end}), 'h145);
    reg_wr(2'd0, 16'h0047);
    chk(range_start == 7 && range_end == 7, "R3", "start write masked",
        int'({range_start, range_end}), 'h1C7);
    reg_wr(2'd1, 16'h00CA);
    chk(range_end == 10, "R4", "end write masked", int'(range_end), 10);
    chk(range_start == 7, "R4", "end write leaves start", int'(range_start), 7);
  endtask

  task automatic t_busy_ignore();
    int nproc;
    int n = 0;
    reg_wr(2'd0, 16'd20);
    reg_wr(2'd1, 16'd40);
    model_cmd('h2A, 20, 40, nproc);
    reg_wr(2'd2, 16'h002A);
    while (!done && n < 1000) begin
      if (n == 2) begin
        reg_addr = 2'd2; reg_wdata = 16'h002C; reg_we = 1'b1;
      end else begin
        reg_we = 1'b0;
      end
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    reg_we = 1'b0;
    chk(n == nproc + 1, "R11", "walk length with command while busy", n, nproc + 1);
    chk(wp_status == 16'h0002, "R11", "status after ignored command", int'(wp_status), 2);
    @(posedge clk);
    @(negedge clk);
    chk(!done && !busy, "R11", "no second walk started", int'({done, busy}), 0);
    check_blocks("R11");
  endtask

  task automatic t_unknown_and_empty();
    int n;
    reg_wr(2'd2, 16'h0055);
    chk(done && cmd_err, "R12", "unknown code done and error", int'({done, cmd_err}), 3);
    chk(wp_status == 16'(exp_wp), "R12", "status kept on unknown", int'(wp_status), exp_wp);
    check_blocks("R12");
    reg_wr(2'd0, 16'd30);
    reg_wr(2'd1, 16'd25);
    reg_wr(2'd2, 16'h0023);
    wait_done(n);
    chk(n == 0, "R12", "empty range done at accept", n, 0);
    chk(!cmd_err, "R12", "error cleared by next command", int'(cmd_err), 0);
    check_blocks("R12");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_range_regs();
    run_cmd('h23, 2, 6, "R5");
    run_cmd('h27, 0, 0, "R9");
    run_cmd('h2A, 8, 15, "R6");
    run_cmd('h2C, 6, 11, "R8");
    run_cmd('h2A, 0, 20, "R7 R6");
    run_cmd('h27, 0, 0, "R7 R9");
    t_busy_ignore();
    t_unknown_and_empty();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule